// File: doc/BRIEF.md
# Alternate Interrupt Location Relocator

This block sits in the interrupt entry path of a processor core. Another unit has already worked out the base handler address and the base machine-state word (MSR) for the incoming interrupt. This block decides whether that interrupt is taken at a relocated vector with address translation left on. When relocation is allowed, it moves the vector to a fixed offset and sets the instruction-relocate and data-relocate bits in the new MSR. When it is not, it passes the base values through unchanged.

Whether relocation is allowed depends on several inputs. The first is a 2-bit generation select. The rest are the class of the cause, the current translation and hypervisor bits, and whether the interrupt raises the hypervisor bit from 0 to 1. Three partition-control fields also take part: a 2-bit level, a radix-mode flag and a hypervisor-relocation enable. Vectored system calls follow their own offset rule. The parameter `REG_OUT` adds one register stage on the outputs.

Top module: `alt_vec_relocator`

## Requirements
- R1: Cause codes 1 (system reset), 2 (machine check) and 3 (hypervisor maintenance) are never relocated, whatever the other inputs are.
- R2: Generation codes 00 and 01 relocate only when the current MSR has both IR (bit 5) and DR (bit 4) set.
- R3: For generation codes 00 and 01, an interrupt that takes HV from 0 (current) to 1 (base MSR bit 60) is not relocated unless the radix flag `lpcr_hr` is 1.
- R4: For generation codes 00 and 01, level values 0 and 1 mean no relocation. Values 2 and 3 relocate at that level.
- R5: For generation code 10, IR and DR must both be set, except when the interrupt takes HV from 0 to 1.
- R6: For generation code 10, when the base MSR has HV=1, relocation needs `lpcr_hail`=1 and then always uses level 3, whatever the level field holds.
- R7: For generation code 10, when the base MSR has HV=0, only level value 3 relocates. Values 1 and 2 act as 0.
- R8: Generation code 11 never relocates.
- R9: When relocation applies, the output MSR is the base MSR with bits 5 and 4 set. Otherwise the output MSR equals the base MSR.
- R10: For any cause other than 4 (vectored system call), a relocated vector is the base ORed with 0x18000 at level 2, or with 0xC000000000004000 at level 3. An unrelocated vector equals the base.
- R11: For cause 4, level 2 leaves the vector unchanged. Level 3 clears bits 0x17000 of the base and then ORs in 0xC000000000003000.
- R12: With `REG_OUT`=1, the outputs and `out_valid` appear on the clock edge after an `in_valid` strobe, and reset clears them to 0. With `REG_OUT`=0, they follow the inputs in the same cycle.
- R13: `applied` is 1 exactly when relocation took effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| gen_sel | input | 2 | Generation: 00/01 older, 10 newest, 11 none |
| cause | input | 3 | Cause class: 0 other, 1 reset, 2 machine check, 3 hv maintenance, 4 vectored syscall |
| cur_ir | input | 1 | Current MSR instruction relocate |
| cur_dr | input | 1 | Current MSR data relocate |
| cur_hv | input | 1 | Current MSR hypervisor bit |
| lpcr_ail | input | 2 | Relocation level field |
| lpcr_hr | input | 1 | Radix-mode flag |
| lpcr_hail | input | 1 | Hypervisor relocation enable |
| base_vec | input | 64 | Base handler address |
| base_msr | input | 64 | Base new MSR (HV at bit 60) |
| out_valid | output | 1 | Output strobe |
| out_vec | output | 64 | Adjusted handler address |
| out_msr | output | 64 | Adjusted new MSR |
| applied | output | 1 | Relocation took effect |

## Verification
The bench builds two copies of the block. One has `REG_OUT`=1 and carries the scoreboard; it exercises the one-cycle latency, the reset values and back-to-back strobes. The other has `REG_OUT`=0 and is checked in the same cycle as each stimulus, so the combinational path is verified on its own. Both copies see every eligibility corner of each generation and both offset rules, so every branch of the decision is compared in each variant.

// File: rtl/alt_vec_pkg.sv
// Shared encodings and offsets for the alternate-vector relocator.
// Assumes a 64-bit address and MSR layout with bit 0 as LSB.
package alt_vec_pkg;
    localparam logic [1:0] GEN_OLD_A = 2'b00;
    localparam logic [1:0] GEN_OLD_B = 2'b01;
    localparam logic [1:0] GEN_NEW   = 2'b10;
    localparam logic [1:0] GEN_NONE  = 2'b11;

    localparam logic [2:0] CAUSE_OTHER  = 3'd0;
    localparam logic [2:0] CAUSE_SRESET = 3'd1;
    localparam logic [2:0] CAUSE_MCHECK = 3'd2;
    localparam logic [2:0] CAUSE_HMAINT = 3'd3;
    localparam logic [2:0] CAUSE_SCV    = 3'd4;

    localparam logic [1:0] LVL_NONE = 2'd0;
    localparam logic [1:0] LVL_TWO  = 2'd2;
    localparam logic [1:0] LVL_THREE = 2'd3;

    localparam logic [63:0] OFS_LVL2      = 64'h0000_0000_0001_8000;
    localparam logic [63:0] OFS_LVL3      = 64'hC000_0000_0000_4000;
    localparam logic [63:0] SCV_BASE_BITS = 64'h0000_0000_0001_7000;
    localparam logic [63:0] SCV_LVL3      = 64'hC000_0000_0000_3000;
endpackage

// File: rtl/alt_vec_elig.sv
// Eligibility decision: returns the effective relocation level (0, 2 or 3).
// Assumes cause codes and generation codes from alt_vec_pkg.
module alt_vec_elig
    import alt_vec_pkg::*;
(
    input  logic [1:0] gen_sel,
    input  logic [2:0] cause,
    input  logic       cur_ir,
    input  logic       cur_dr,
    input  logic       cur_hv,
    input  logic       new_hv,
    input  logic [1:0] lpcr_ail,
    input  logic       lpcr_hr,
    input  logic       lpcr_hail,
    output logic [1:0] level
);
    logic mmu_on;
    logic escalate;
    logic protected_cause;

    assign mmu_on   = cur_ir & cur_dr;
    assign escalate = ~cur_hv & new_hv;
    assign protected_cause = (cause == CAUSE_SRESET) || (cause == CAUSE_MCHECK) ||
                             (cause == CAUSE_HMAINT);

    // Purpose: apply the per-generation rules to pick the effective level.
    always_comb begin
        level = LVL_NONE;
        if (!protected_cause) begin
            case (gen_sel)
                GEN_OLD_A, GEN_OLD_B: begin
                    if (mmu_on && !(escalate && !lpcr_hr) && lpcr_ail[1])
                        level = lpcr_ail;
                end
                GEN_NEW: begin
                    if (mmu_on || escalate) begin
                        if (new_hv)
                            level = lpcr_hail ? LVL_THREE : LVL_NONE;
                        else if (lpcr_ail == LVL_THREE)
                            level = LVL_THREE;
                    end
                end
                default: level = LVL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/alt_vec_adjust.sv
// Applies the chosen level to the base vector and base MSR.
// Assumes level is 0, 2 or 3; vectored system calls use their own offset rule.
module alt_vec_adjust
    import alt_vec_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int IR_BIT = 5,
    parameter int DR_BIT = 4
) (
    input  logic [1:0]      level,
    input  logic            is_scv,
    input  logic [XLEN-1:0] base_vec,
    input  logic [XLEN-1:0] base_msr,
    output logic [XLEN-1:0] vec,
    output logic [XLEN-1:0] msr,
    output logic            applied
);
    localparam logic [XLEN-1:0] XLAT_BITS = (XLEN'(1) << IR_BIT) | (XLEN'(1) << DR_BIT);
    localparam logic [XLEN-1:0] L2_OFS    = XLEN'(OFS_LVL2);
    localparam logic [XLEN-1:0] L3_OFS    = XLEN'(OFS_LVL3);
    localparam logic [XLEN-1:0] SCV_CLR   = XLEN'(SCV_BASE_BITS);
    localparam logic [XLEN-1:0] SCV_L3    = XLEN'(SCV_LVL3);

    assign applied = (level != LVL_NONE);

    // Purpose: force translation on in the handler MSR when relocating.
    always_comb begin
        msr = applied ? (base_msr | XLAT_BITS) : base_msr;
    end

    // Purpose: form the relocated vector for normal and vectored-syscall entry.
    always_comb begin
        vec = base_vec;
        if (is_scv) begin
            if (level == LVL_THREE)
                vec = (base_vec & ~SCV_CLR) | SCV_L3;
        end else begin
            if (level == LVL_TWO)
                vec = base_vec | L2_OFS;
            else if (level == LVL_THREE)
                vec = base_vec | L3_OFS;
        end
    end
endmodule

// File: rtl/alt_vec_stage.sv
// Optional output stage: a register when REG_OUT=1, a wire otherwise.
// Assumes synchronous active-low reset; registered data hold between strobes.
module alt_vec_stage #(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            d_valid,
    input  logic [XLEN-1:0] d_vec,
    input  logic [XLEN-1:0] d_msr,
    input  logic            d_applied,
    output logic            q_valid,
    output logic [XLEN-1:0] q_vec,
    output logic [XLEN-1:0] q_msr,
    output logic            q_applied
);
    generate
        if (REG_OUT) begin : g_reg
            // Purpose: capture results on a strobe, clear everything on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_valid   <= 1'b0;
                    q_vec     <= '0;
                    q_msr     <= '0;
                    q_applied <= 1'b0;
                end else begin
                    q_valid <= d_valid;
                    if (d_valid) begin
                        q_vec     <= d_vec;
                        q_msr     <= d_msr;
                        q_applied <= d_applied;
                    end
                end
            end
        end else begin : g_wire
            assign q_valid   = d_valid;
            assign q_vec     = d_vec;
            assign q_msr     = d_msr;
            assign q_applied = d_applied;
        end
    endgenerate
endmodule

// File: rtl/alt_vec_relocator.sv
// Top: decides alternate-location delivery and adjusts vector and MSR.
// Assumes the base vector and base MSR are already formed upstream.
module alt_vec_relocator
    import alt_vec_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int IR_BIT  = 5,
    parameter int DR_BIT  = 4,
    parameter int HV_BIT  = 60,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      gen_sel,
    input  logic [2:0]      cause,
    input  logic            cur_ir,
    input  logic            cur_dr,
    input  logic            cur_hv,
    input  logic [1:0]      lpcr_ail,
    input  logic            lpcr_hr,
    input  logic            lpcr_hail,
    input  logic [XLEN-1:0] base_vec,
    input  logic [XLEN-1:0] base_msr,
    output logic            out_valid,
    output logic [XLEN-1:0] out_vec,
    output logic [XLEN-1:0] out_msr,
    output logic            applied
);
    logic [1:0]      level;
    logic [XLEN-1:0] adj_vec;
    logic [XLEN-1:0] adj_msr;
    logic            adj_applied;

    alt_vec_elig u_elig (
        .gen_sel   (gen_sel),
        .cause     (cause),
        .cur_ir    (cur_ir),
        .cur_dr    (cur_dr),
        .cur_hv    (cur_hv),
        .new_hv    (base_msr[HV_BIT]),
        .lpcr_ail  (lpcr_ail),
        .lpcr_hr   (lpcr_hr),
        .lpcr_hail (lpcr_hail),
        .level     (level)
    );

    alt_vec_adjust #(.XLEN(XLEN), .IR_BIT(IR_BIT), .DR_BIT(DR_BIT)) u_adjust (
        .level    (level),
        .is_scv   (cause == CAUSE_SCV),
        .base_vec (base_vec),
        .base_msr (base_msr),
        .vec      (adj_vec),
        .msr      (adj_msr),
        .applied  (adj_applied)
    );

    alt_vec_stage #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_valid   (in_valid),
        .d_vec     (adj_vec),
        .d_msr     (adj_msr),
        .d_applied (adj_applied),
        .q_valid   (out_valid),
        .q_vec     (out_vec),
        .q_msr     (out_msr),
        .q_applied (applied)
    );
endmodule

// File: rtl/alt_vec_relocator_chk.sv
// Checker bound to alt_vec_relocator: aligns inputs to the output stage and
// checks the relocation rules at the ports.
module alt_vec_relocator_chk
    import alt_vec_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int IR_BIT  = 5,
    parameter int DR_BIT  = 4,
    parameter int HV_BIT  = 60,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      gen_sel,
    input  logic [2:0]      cause,
    input  logic            cur_ir,
    input  logic            cur_dr,
    input  logic            cur_hv,
    input  logic            lpcr_hail,
    input  logic [XLEN-1:0] base_vec,
    input  logic [XLEN-1:0] base_msr,
    input  logic            out_valid,
    input  logic [XLEN-1:0] out_vec,
    input  logic [XLEN-1:0] out_msr,
    input  logic            applied
);
    logic [1:0]      s_gen;
    logic [2:0]      s_cause;
    logic            s_mmu;
    logic            s_hail;
    logic [XLEN-1:0] s_vec;
    logic [XLEN-1:0] s_msr;

    generate
        if (REG_OUT) begin : g_align
            // Purpose: hold the inputs of the last strobe beside the outputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_gen <= GEN_NONE; s_cause <= CAUSE_OTHER; s_mmu <= 1'b0;
                    s_hail <= 1'b0; s_vec <= '0; s_msr <= '0;
                end else if (in_valid) begin
                    s_gen <= gen_sel; s_cause <= cause; s_mmu <= cur_ir & cur_dr;
                    s_hail <= lpcr_hail; s_vec <= base_vec; s_msr <= base_msr;
                end
            end
            assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
        end else begin : g_align
            assign s_gen = gen_sel; assign s_cause = cause; assign s_mmu = cur_ir & cur_dr;
            assign s_hail = lpcr_hail; assign s_vec = base_vec; assign s_msr = base_msr;
        end
    endgenerate

    assert_protected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (s_cause == CAUSE_SRESET || s_cause == CAUSE_MCHECK ||
                       s_cause == CAUSE_HMAINT)) |-> !applied);
    assert_older_mmu_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && applied && !s_gen[1]) |-> s_mmu);
    assert_new_hail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && applied && s_gen == GEN_NEW && s_msr[HV_BIT]) |-> s_hail);
    assert_none_gen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && s_gen == GEN_NONE) |-> !applied);
    assert_msr_xlat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && applied) |-> (out_msr[IR_BIT] && out_msr[DR_BIT]));
    assert_passthru_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !applied) |-> (out_vec == s_vec && out_msr == s_msr));
endmodule

bind alt_vec_relocator alt_vec_relocator_chk #(
    .XLEN(XLEN), .IR_BIT(IR_BIT), .DR_BIT(DR_BIT), .HV_BIT(HV_BIT), .REG_OUT(REG_OUT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gen_sel(gen_sel), .cause(cause),
    .cur_ir(cur_ir), .cur_dr(cur_dr), .cur_hv(cur_hv), .lpcr_hail(lpcr_hail),
    .base_vec(base_vec), .base_msr(base_msr), .out_valid(out_valid),
    .out_vec(out_vec), .out_msr(out_msr), .applied(applied)
);

// File: tb/alt_vec_relocator_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results, the monitor pops them.
module alt_vec_relocator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  gen_sel = 2'b11;
    logic [2:0]  cause = 3'd0;
    logic        cur_ir = 1'b0, cur_dr = 1'b0, cur_hv = 1'b0;
    logic [1:0]  lpcr_ail = 2'd0;
    logic        lpcr_hr = 1'b0, lpcr_hail = 1'b0;
    logic [63:0] base_vec = '0, base_msr = '0;

    logic        out_valid, applied, c_valid, c_applied;
    logic [63:0] out_vec, out_msr, c_vec, c_msr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] q_vec[$];
    logic [63:0] q_msr[$];
    logic        q_app[$];
    string       q_tag[$];

    localparam logic [63:0] HV  = 64'h1000_0000_0000_0000;
    localparam logic [63:0] XL  = 64'h30;

    always #4 clk = ~clk;

    alt_vec_relocator #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gen_sel(gen_sel), .cause(cause),
        .cur_ir(cur_ir), .cur_dr(cur_dr), .cur_hv(cur_hv), .lpcr_ail(lpcr_ail),
        .lpcr_hr(lpcr_hr), .lpcr_hail(lpcr_hail), .base_vec(base_vec), .base_msr(base_msr),
        .out_valid(out_valid), .out_vec(out_vec), .out_msr(out_msr), .applied(applied));

    alt_vec_relocator #(.REG_OUT(1'b0)) dut_comb_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gen_sel(gen_sel), .cause(cause),
        .cur_ir(cur_ir), .cur_dr(cur_dr), .cur_hv(cur_hv), .lpcr_ail(lpcr_ail),
        .lpcr_hr(lpcr_hr), .lpcr_hail(lpcr_hail), .base_vec(base_vec), .base_msr(base_msr),
        .out_valid(c_valid), .out_vec(c_vec), .out_msr(c_msr), .applied(c_applied));

    // Level the requirements predict (0 = none).
    function automatic int exp_level(input logic [1:0] g, input logic [2:0] c,
                                     input logic ir, input logic dr, input logic hv,
                                     input logic nhv, input logic [1:0] ail,
                                     input logic hr, input logic hail);
        int lv = 0;
        if (c >= 3'd1 && c <= 3'd3) return 0;          // R1
        if (g == 2'b00 || g == 2'b01) begin
            if (ir && dr && (hv || !nhv || hr) && ail >= 2) lv = int'(ail); // R2 R3 R4
        end else if (g == 2'b10) begin
            if ((ir && dr) || (!hv && nhv)) begin        // R5
                if (nhv) lv = hail ? 3 : 0;              // R6
                else lv = (ail == 2'd3) ? 3 : 0;         // R7
            end
        end
        return lv;                                       // R8
    endfunction

    task automatic check(input string tag, input logic [63:0] av, input logic [63:0] am,
                         input logic aa, input logic [63:0] ev, input logic [63:0] em,
                         input logic ea);
        checks++;
        if (av !== ev || am !== em || aa !== ea) begin
            errors++;
            $display("FAIL %s: vec=%h msr=%h applied=%b expected vec=%h msr=%h applied=%b",
                     tag, av, am, aa, ev, em, ea);
        end
    endtask

    task automatic run(input string tag, input logic [1:0] g, input logic [2:0] c,
                       input logic ir, input logic dr, input logic hv,
                       input logic [63:0] bm, input logic [1:0] ail, input logic hr,
                       input logic hail, input logic [63:0] bv);
        int lv;
        logic [63:0] ev, em;
        lv = exp_level(g, c, ir, dr, hv, bm[60], ail, hr, hail);
        ev = bv;
        em = (lv != 0) ? (bm | XL) : bm;                      // R9
        if (c == 3'd4) begin
            if (lv == 3) ev = (bv & ~64'h17000) | 64'hC000_0000_0000_3000; // R11
        end else if (lv == 2) ev = bv | 64'h18000;             // R10
        else if (lv == 3) ev = bv | 64'hC000_0000_0000_4000;
        q_vec.push_back(ev); q_msr.push_back(em); q_app.push_back(lv != 0); q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b1; gen_sel = g; cause = c; cur_ir = ir; cur_dr = dr; cur_hv = hv;
        base_msr = bm; lpcr_ail = ail; lpcr_hr = hr; lpcr_hail = hail; base_vec = bv;
        #1;
        check({tag, " R12 comb"}, c_vec, c_msr, c_applied, ev, em, lv != 0);
    endtask

    // Monitor: pop one expected item per registered output strobe.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_vec.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12: unexpected out_valid, expected none");
            end else begin
                check(q_tag.pop_front(), out_vec, out_msr, applied,
                      q_vec.pop_front(), q_msr.pop_front(), q_app.pop_front());
            end
        end
    end

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset", {63'd0, out_valid}, out_msr, applied, 64'd0, 64'd0, 1'b0);
        check("R12 reset vec", out_vec, 64'd0, 1'b0, 64'd0, 64'd0, 1'b0);
        rst_n = 1'b1;
        // R1: protected causes
        run("R1 sreset",  2'b00, 3'd1, 1, 1, 1, HV, 2'd3, 1, 1, 64'h100);
        run("R1 mcheck",  2'b10, 3'd2, 1, 1, 1, HV, 2'd3, 1, 1, 64'h200);
        run("R1 hmaint",  2'b10, 3'd3, 1, 1, 0, HV, 2'd3, 1, 1, 64'hE60);
        // R2
        run("R2 dr off",  2'b00, 3'd0, 1, 0, 0, 64'd0, 2'd3, 0, 0, 64'h500);
        run("R2 mmu on",  2'b01, 3'd0, 1, 1, 0, 64'd0, 2'd3, 0, 0, 64'h500);
        // R3
        run("R3 esc hpt", 2'b00, 3'd0, 1, 1, 0, HV, 2'd3, 0, 0, 64'h980);
        run("R3 esc rdx", 2'b00, 3'd0, 1, 1, 0, HV, 2'd3, 1, 0, 64'h980);
        run("R3 hv to hv",2'b01, 3'd0, 1, 1, 1, HV, 2'd2, 0, 0, 64'h980);
        // R4
        run("R4 ail0",    2'b01, 3'd0, 1, 1, 0, 64'd0, 2'd0, 0, 0, 64'h500);
        run("R4 ail1",    2'b01, 3'd0, 1, 1, 0, 64'd0, 2'd1, 0, 0, 64'h500);
        run("R4 ail2",    2'b01, 3'd0, 1, 1, 0, 64'd0, 2'd2, 0, 0, 64'h500);
        // R5
        run("R5 mmu off", 2'b10, 3'd0, 0, 0, 0, 64'd0, 2'd3, 0, 1, 64'h900);
        run("R5 esc",     2'b10, 3'd0, 0, 0, 0, HV, 2'd0, 0, 1, 64'h980);
        // R6
        run("R6 no hail", 2'b10, 3'd0, 1, 1, 1, HV, 2'd3, 0, 0, 64'h980);
        run("R6 hail",    2'b10, 3'd0, 1, 1, 1, HV, 2'd0, 0, 1, 64'h980);
        // R7
        run("R7 ail2",    2'b10, 3'd0, 1, 1, 0, 64'd0, 2'd2, 0, 1, 64'h500);
        run("R7 ail3",    2'b10, 3'd0, 1, 1, 0, 64'd0, 2'd3, 0, 0, 64'h500);
        // R8
        run("R8 none",    2'b11, 3'd0, 1, 1, 1, HV, 2'd3, 1, 1, 64'h500);
        // R9 R13: other MSR bits preserved
        run("R9 keep",    2'b00, 3'd0, 1, 1, 1, 64'h9000_0000_0000_1001, 2'd3, 0, 0, 64'h700);
        run("R13 flag",   2'b00, 3'd0, 1, 1, 1, 64'h9000_0000_0000_1001, 2'd1, 0, 0, 64'h700);
        // R10 R11: vectored syscall offsets
        run("R10 l3",     2'b00, 3'd0, 1, 1, 0, 64'd0, 2'd3, 0, 0, 64'hC00);
        run("R11 scv l2", 2'b00, 3'd4, 1, 1, 0, 64'd0, 2'd2, 0, 0, 64'h17020);
        run("R11 scv l3", 2'b10, 3'd4, 1, 1, 0, 64'd0, 2'd3, 0, 0, 64'h17020);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (q_vec.size() != 0) begin
            errors++;
            $display("FAIL R12: %0d results missing, expected 0", q_vec.size());
        end
        finish_run();
    end
endmodule